// File: doc/BRIEF.md
# Serial audio frame-sync pin controller

This block owns the two frame-sync pads of a serial audio port, one on the receive side and one on the transmit side. From a handful of control bits it decides what each pad does. The pad can be a frame-sync input or output, a serial flag, an enable for an external transmit buffer, or a plain general-purpose pin that is disconnected, an input or an output. The block produces the pad drive value and output enable for each pad. It also produces the frame-sync strobes that the receive and transmit logic consume.

In synchronous operation the transmit frame-sync path times both directions. The receive pad is then free for one of three uses: a flag bit, a buffer enable, or nothing. A flag written to the pad, or read from it, moves only on a timing strobe. That strobe is the frame sync in normal mode and the per-slot pulse in network mode. As a result, the serial side sees flag changes at well-defined points in the frame.

Top module: `fsp_pin_ctl`

## Requirements
- R1: While `rst_ni` is low, both pads are general-purpose disconnected. Both output enables, both pad drives, `rx_fs_o`, `tx_fs_o`, both `*_gpio_in_o` and `if1_o` are 0, whatever the other inputs are.
- R2: The pad-role controls are `sync_mode_i`, `buf_en_sel_i`, `rx_dir_out_i`, `tx_dir_out_i`, `*_gpio_sel_i` and `*_gpio_cfg_i`. They are registered, so a change takes effect on the pads one clock edge later. `net_mode_i` and all data and strobe inputs act combinationally.
- R3: A pad whose `*_gpio_sel_i` is 1 is a general-purpose pin. With config 1 it is an input: output enable 0, and `*_gpio_in_o` equals the pad level. With config 2 it is an output: output enable 1, and it drives `*_gpio_out_i`. With config 0 or 3 it is disconnected: output enable 0 and drive 0. Each pad is configured independently of the other.
- R4: With `sync_mode_i`=0 and the receive pad not in general-purpose mode, the receive pad is frame sync. When `rx_dir_out_i`=1 it drives `rx_fs_int_i` with output enable 1, and `rx_fs_o` equals `rx_fs_int_i`. When `rx_dir_out_i`=0 its output enable is 0 and `rx_fs_o` equals the pad level.
- R5: When the transmit pad is not in general-purpose mode it is frame sync in both synchronous and asynchronous mode. When `tx_dir_out_i`=1 it drives `tx_fs_int_i` with output enable 1, and `tx_fs_o` equals `tx_fs_int_i`. Otherwise `tx_fs_o` follows the pad level. In general-purpose mode `tx_fs_o` is 0.
- R6: With `sync_mode_i`=1, `rx_fs_o` equals `tx_fs_o` whatever the receive pad does. With `sync_mode_i`=0 and the receive pad in general-purpose mode, `rx_fs_o` is 0.
- R7: With `sync_mode_i`=1, `buf_en_sel_i`=0 and `rx_dir_out_i`=1, the receive pad is the output flag. Its output enable is 1 and it drives a held flag register, which is 0 after reset. On a clock edge with the flag strobe high, that register loads `of1_bit_i`, and the pad shows the new value from the next cycle.
- R8: The flag strobe is `tx_fs_o` when `net_mode_i`=0 and `slot_strobe_i` when `net_mode_i`=1. In each case the other signal has no effect on either flag.
- R9: With `sync_mode_i`=1, `buf_en_sel_i`=0 and `rx_dir_out_i`=0, the receive pad is the input flag with output enable 0. On a clock edge with the flag strobe high, `if1_o` loads the pad level. At every other edge, and in every other mode, `if1_o` holds its value.
- R10: With `sync_mode_i`=1, `buf_en_sel_i`=1 and `rx_dir_out_i`=1, the receive pad drives `tx_active_i` with output enable 1.
- R11: With `sync_mode_i`=1, `buf_en_sel_i`=1 and `rx_dir_out_i`=0, the receive pad is idle. Its output enable is 0 and its drive is 0.
- R12: A pad not in general-purpose input mode reports 0 on its `*_gpio_in_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | 1: transmit frame sync times both directions |
| buf_en_sel_i | input | 1 | Synchronous mode: receive pad used as buffer enable |
| rx_dir_out_i | input | 1 | Receive pad direction/function select |
| tx_dir_out_i | input | 1 | Transmit pad direction, 1 = output |
| net_mode_i | input | 1 | 1: flags timed by slot strobe |
| rx_gpio_sel_i | input | 1 | Receive pad in general-purpose mode |
| rx_gpio_cfg_i | input | 2 | Receive pad GP config: 0 off, 1 in, 2 out, 3 off |
| rx_gpio_out_i | input | 1 | Receive pad GP output value |
| tx_gpio_sel_i | input | 1 | Transmit pad in general-purpose mode |
| tx_gpio_cfg_i | input | 2 | Transmit pad GP config: 0 off, 1 in, 2 out, 3 off |
| tx_gpio_out_i | input | 1 | Transmit pad GP output value |
| rx_fs_int_i | input | 1 | Internally generated receive frame sync |
| tx_fs_int_i | input | 1 | Internally generated transmit frame sync |
| slot_strobe_i | input | 1 | One-cycle pulse at each slot start |
| tx_active_i | input | 1 | Transmitter is shifting an active slot |
| of1_bit_i | input | 1 | Output flag control bit |
| rx_pin_i | input | 1 | Receive pad level |
| tx_pin_i | input | 1 | Transmit pad level |
| rx_pin_o | output | 1 | Receive pad drive value |
| rx_pin_oe_o | output | 1 | Receive pad output enable |
| tx_pin_o | output | 1 | Transmit pad drive value |
| tx_pin_oe_o | output | 1 | Transmit pad output enable |
| rx_fs_o | output | 1 | Frame sync to receive logic |
| tx_fs_o | output | 1 | Frame sync to transmit logic |
| rx_gpio_in_o | output | 1 | Receive pad GP input value |
| tx_gpio_in_o | output | 1 | Transmit pad GP input value |
| if1_o | output | 1 | Captured input flag status |

## Verification
The role logic is swept over all 1024 settings of the pad-role controls. Under each setting, all 128 combinations of the two internal frame syncs, the two pad levels, the two GP outputs and the transmit-active line are applied. This separates the general-purpose, frame-sync, flag, buffer-enable and idle roles, and exposes any input that leaks into the wrong pad. The flag paths are then driven with pseudo-random mixes of frame-sync pulses, slot pulses, network-mode changes, flag values and pad levels. This shows whether the flag moves on the right strobe, ignores the wrong one, and holds between strobes. A reset phase with active inputs and a one-edge latency probe cover the reset state and the register stage.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  localparam int unsigned GP_CFG_W = 2;

  typedef enum logic [GP_CFG_W-1:0] {
    GP_OFF = 2'd0,
    GP_IN  = 2'd1,
    GP_OUT = 2'd2,
    GP_RSV = 2'd3
  } gp_cfg_e;

  typedef enum logic [3:0] {
    RXM_OFF,
    RXM_GIN,
    RXM_GOUT,
    RXM_FS_IN,
    RXM_FS_OUT,
    RXM_FLG_IN,
    RXM_FLG_OUT,
    RXM_BUFEN,
    RXM_IDLE
  } rx_mode_e;

  typedef enum logic [2:0] {
    TXM_OFF,
    TXM_GIN,
    TXM_GOUT,
    TXM_FS_IN,
    TXM_FS_OUT
  } tx_mode_e;

  function automatic rx_mode_e rx_decode(input logic gsel, input logic [GP_CFG_W-1:0] cfg,
                                         input logic sync, input logic tebe, input logic rdir);
    rx_mode_e m;
    if (gsel) begin
      case (gp_cfg_e'(cfg))
        GP_IN:   m = RXM_GIN;
        GP_OUT:  m = RXM_GOUT;
        default: m = RXM_OFF;
      endcase
    end else if (!sync) begin
      m = rdir ? RXM_FS_OUT : RXM_FS_IN;
    end else if (!tebe) begin
      m = rdir ? RXM_FLG_OUT : RXM_FLG_IN;
    end else begin
      m = rdir ? RXM_BUFEN : RXM_IDLE;
    end
    return m;
  endfunction

  function automatic tx_mode_e tx_decode(input logic gsel, input logic [GP_CFG_W-1:0] cfg,
                                         input logic tdir);
    tx_mode_e m;
    if (gsel) begin
      case (gp_cfg_e'(cfg))
        GP_IN:   m = TXM_GIN;
        GP_OUT:  m = TXM_GOUT;
        default: m = TXM_OFF;
      endcase
    end else begin
      m = tdir ? TXM_FS_OUT : TXM_FS_IN;
    end
    return m;
  endfunction

endpackage

// File: rtl/fsp_mode_reg.sv
module fsp_mode_reg
  import fsp_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sync_i,
  input  logic                tebe_i,
  input  logic                rdir_i,
  input  logic                tdir_i,
  input  logic                rx_gsel_i,
  input  logic [GP_CFG_W-1:0] rx_gcfg_i,
  input  logic                tx_gsel_i,
  input  logic [GP_CFG_W-1:0] tx_gcfg_i,
  output rx_mode_e            rx_mode_o,
  output tx_mode_e            tx_mode_o,
  output logic                sync_o
);

  rx_mode_e rx_mode_q;
  tx_mode_e tx_mode_q;
  logic     sync_q;

  // reset state: both pads GP disconnected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_mode_q <= RXM_OFF;
      tx_mode_q <= TXM_OFF;
      sync_q    <= 1'b0;
    end else begin
      rx_mode_q <= rx_decode(rx_gsel_i, rx_gcfg_i, sync_i, tebe_i, rdir_i);
      tx_mode_q <= tx_decode(tx_gsel_i, tx_gcfg_i, tdir_i);
      sync_q    <= sync_i;
    end
  end

  assign rx_mode_o = rx_mode_q;
  assign tx_mode_o = tx_mode_q;
  assign sync_o    = sync_q;

endmodule

// File: rtl/fsp_tx_pin.sv
module fsp_tx_pin
  import fsp_pkg::*;
(
  input  tx_mode_e mode_i,
  input  logic     fs_int_i,
  input  logic     pin_i,
  input  logic     gout_i,
  output logic     pin_o,
  output logic     oe_o,
  output logic     fs_o,
  output logic     gin_o
);

  always_comb begin
    pin_o = 1'b0;
    oe_o  = 1'b0;
    fs_o  = 1'b0;
    gin_o = 1'b0;
    case (mode_i)
      TXM_GIN:    gin_o = pin_i;
      TXM_GOUT:   begin pin_o = gout_i;   oe_o = 1'b1; end
      TXM_FS_IN:  fs_o = pin_i;
      TXM_FS_OUT: begin pin_o = fs_int_i; oe_o = 1'b1; fs_o = fs_int_i; end
      default: ;
    endcase
  end

endmodule

// File: rtl/fsp_rx_pin.sv
module fsp_rx_pin
  import fsp_pkg::*;
(
  input  rx_mode_e mode_i,
  input  logic     sync_i,
  input  logic     tx_fs_i,
  input  logic     fs_int_i,
  input  logic     pin_i,
  input  logic     gout_i,
  input  logic     of1_i,
  input  logic     tx_active_i,
  output logic     pin_o,
  output logic     oe_o,
  output logic     fs_o,
  output logic     gin_o
);

  logic own_fs;

  always_comb begin
    pin_o  = 1'b0;
    oe_o   = 1'b0;
    gin_o  = 1'b0;
    own_fs = 1'b0;
    case (mode_i)
      RXM_GIN:     gin_o = pin_i;
      RXM_GOUT:    begin pin_o = gout_i;      oe_o = 1'b1; end
      RXM_FS_IN:   own_fs = pin_i;
      RXM_FS_OUT:  begin pin_o = fs_int_i;    oe_o = 1'b1; own_fs = fs_int_i; end
      RXM_FLG_OUT: begin pin_o = of1_i;       oe_o = 1'b1; end
      RXM_BUFEN:   begin pin_o = tx_active_i; oe_o = 1'b1; end
      default: ;
    endcase
    // synchronous mode: receiver timed by transmit frame sync
    fs_o = sync_i ? tx_fs_i : own_fs;
  end

endmodule

// File: rtl/fsp_flag_unit.sv
module fsp_flag_unit #(
  parameter logic FLAG_RST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic net_mode_i,
  input  logic frame_i,
  input  logic slot_i,
  input  logic out_en_i,
  input  logic in_en_i,
  input  logic of1_bit_i,
  input  logic pin_i,
  output logic of1_o,
  output logic if1_o
);

  logic strobe;
  logic of1_q, if1_q;

  assign strobe = net_mode_i ? slot_i : frame_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      of1_q <= FLAG_RST;
      if1_q <= FLAG_RST;
    end else begin
      if (strobe && out_en_i) of1_q <= of1_bit_i;
      if (strobe && in_en_i)  if1_q <= pin_i;
    end
  end

  assign of1_o = of1_q;
  assign if1_o = if1_q;

endmodule

// File: rtl/fsp_pin_ctl.sv
module fsp_pin_ctl
  import fsp_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sync_mode_i,
  input  logic                buf_en_sel_i,
  input  logic                rx_dir_out_i,
  input  logic                tx_dir_out_i,
  input  logic                net_mode_i,
  input  logic                rx_gpio_sel_i,
  input  logic [GP_CFG_W-1:0] rx_gpio_cfg_i,
  input  logic                rx_gpio_out_i,
  input  logic                tx_gpio_sel_i,
  input  logic [GP_CFG_W-1:0] tx_gpio_cfg_i,
  input  logic                tx_gpio_out_i,
  input  logic                rx_fs_int_i,
  input  logic                tx_fs_int_i,
  input  logic                slot_strobe_i,
  input  logic                tx_active_i,
  input  logic                of1_bit_i,
  input  logic                rx_pin_i,
  input  logic                tx_pin_i,
  output logic                rx_pin_o,
  output logic                rx_pin_oe_o,
  output logic                tx_pin_o,
  output logic                tx_pin_oe_o,
  output logic                rx_fs_o,
  output logic                tx_fs_o,
  output logic                rx_gpio_in_o,
  output logic                tx_gpio_in_o,
  output logic                if1_o
);

  rx_mode_e rx_mode;
  tx_mode_e tx_mode;
  logic     sync_q;
  logic     of1_q;
  logic     tx_fs;

  fsp_mode_reg u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync_mode_i),
    .tebe_i    (buf_en_sel_i),
    .rdir_i    (rx_dir_out_i),
    .tdir_i    (tx_dir_out_i),
    .rx_gsel_i (rx_gpio_sel_i),
    .rx_gcfg_i (rx_gpio_cfg_i),
    .tx_gsel_i (tx_gpio_sel_i),
    .tx_gcfg_i (tx_gpio_cfg_i),
    .rx_mode_o (rx_mode),
    .tx_mode_o (tx_mode),
    .sync_o    (sync_q)
  );

  fsp_tx_pin u_tx (
    .mode_i   (tx_mode),
    .fs_int_i (tx_fs_int_i),
    .pin_i    (tx_pin_i),
    .gout_i   (tx_gpio_out_i),
    .pin_o    (tx_pin_o),
    .oe_o     (tx_pin_oe_o),
    .fs_o     (tx_fs),
    .gin_o    (tx_gpio_in_o)
  );

  fsp_flag_unit #(.FLAG_RST(1'b0)) u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .net_mode_i (net_mode_i),
    .frame_i    (tx_fs),
    .slot_i     (slot_strobe_i),
    .out_en_i   (rx_mode == RXM_FLG_OUT),
    .in_en_i    (rx_mode == RXM_FLG_IN),
    .of1_bit_i  (of1_bit_i),
    .pin_i      (rx_pin_i),
    .of1_o      (of1_q),
    .if1_o      (if1_o)
  );

  fsp_rx_pin u_rx (
    .mode_i      (rx_mode),
    .sync_i      (sync_q),
    .tx_fs_i     (tx_fs),
    .fs_int_i    (rx_fs_int_i),
    .pin_i       (rx_pin_i),
    .gout_i      (rx_gpio_out_i),
    .of1_i       (of1_q),
    .tx_active_i (tx_active_i),
    .pin_o       (rx_pin_o),
    .oe_o        (rx_pin_oe_o),
    .fs_o        (rx_fs_o),
    .gin_o       (rx_gpio_in_o)
  );

  assign tx_fs_o = tx_fs;

endmodule

// File: rtl/fsp_chk.sv
module fsp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sync_mode_i,
  input logic       buf_en_sel_i,
  input logic       rx_dir_out_i,
  input logic       tx_dir_out_i,
  input logic       net_mode_i,
  input logic       rx_gpio_sel_i,
  input logic [1:0] rx_gpio_cfg_i,
  input logic       tx_gpio_sel_i,
  input logic       tx_fs_int_i,
  input logic       slot_strobe_i,
  input logic       tx_active_i,
  input logic       of1_bit_i,
  input logic       rx_pin_i,
  input logic       rx_pin_o,
  input logic       rx_pin_oe_o,
  input logic       tx_pin_o,
  input logic       tx_pin_oe_o,
  input logic       rx_fs_o,
  input logic       tx_fs_o,
  input logic       rx_gpio_in_o,
  input logic       if1_o
);

  logic up_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) up_q <= 1'b0;
    else         up_q <= 1'b1;
  end

  logic cfg_fo, cfg_fi, cfg_be, cfg_idle, cfg_roff, cfg_tfs_out, strb;
  assign cfg_fo      = !rx_gpio_sel_i && sync_mode_i && !buf_en_sel_i && rx_dir_out_i;
  assign cfg_fi      = !rx_gpio_sel_i && sync_mode_i && !buf_en_sel_i && !rx_dir_out_i;
  assign cfg_be      = !rx_gpio_sel_i && sync_mode_i && buf_en_sel_i && rx_dir_out_i;
  assign cfg_idle    = !rx_gpio_sel_i && sync_mode_i && buf_en_sel_i && !rx_dir_out_i;
  assign cfg_roff    = rx_gpio_sel_i && (rx_gpio_cfg_i == 2'd0 || rx_gpio_cfg_i == 2'd3);
  assign cfg_tfs_out = !tx_gpio_sel_i && tx_dir_out_i;
  assign strb        = net_mode_i ? slot_strobe_i : tx_fs_o;

  // R3
  rx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && $past(cfg_roff)) |-> (!rx_pin_oe_o && !rx_pin_o && !rx_gpio_in_o));

  // R5
  tx_fs_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && $past(cfg_tfs_out)) |-> (tx_pin_oe_o && tx_pin_o == tx_fs_int_i && tx_fs_o == tx_fs_int_i));

  // R6
  sync_fs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && $past(sync_mode_i)) |-> (rx_fs_o == tx_fs_o));

  // R7
  of1_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && $past(cfg_fo) && cfg_fo && strb) |=> (rx_pin_oe_o && rx_pin_o == $past(of1_bit_i)));

  // R8
  of1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && $past(cfg_fo) && cfg_fo && !strb) |=> $stable(rx_pin_o));

  // R9
  if1_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && $past(cfg_fi) && strb) |=> (if1_o == $past(rx_pin_i)));

  // R9
  if1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(up_q && $past(cfg_fi) && strb)) |=> $stable(if1_o));

  // R10
  bufen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && $past(cfg_be)) |-> (rx_pin_oe_o && rx_pin_o == tx_active_i));

  // R11
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && $past(cfg_idle)) |-> (!rx_pin_oe_o && !rx_pin_o));

endmodule

bind fsp_pin_ctl fsp_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sync_mode_i   (sync_mode_i),
  .buf_en_sel_i  (buf_en_sel_i),
  .rx_dir_out_i  (rx_dir_out_i),
  .tx_dir_out_i  (tx_dir_out_i),
  .net_mode_i    (net_mode_i),
  .rx_gpio_sel_i (rx_gpio_sel_i),
  .rx_gpio_cfg_i (rx_gpio_cfg_i),
  .tx_gpio_sel_i (tx_gpio_sel_i),
  .tx_fs_int_i   (tx_fs_int_i),
  .slot_strobe_i (slot_strobe_i),
  .tx_active_i   (tx_active_i),
  .of1_bit_i     (of1_bit_i),
  .rx_pin_i      (rx_pin_i),
  .rx_pin_o      (rx_pin_o),
  .rx_pin_oe_o   (rx_pin_oe_o),
  .tx_pin_o      (tx_pin_o),
  .tx_pin_oe_o   (tx_pin_oe_o),
  .rx_fs_o       (rx_fs_o),
  .tx_fs_o       (tx_fs_o),
  .rx_gpio_in_o  (rx_gpio_in_o),
  .if1_o         (if1_o)
);

// File: tb/tb_fsp_pin_ctl.sv
module tb_fsp_pin_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 200000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sync_mode, buf_en_sel, rx_dir_out, tx_dir_out, net_mode;
  logic rx_gsel, tx_gsel, rx_gout, tx_gout;
  logic [1:0] rx_gcfg, tx_gcfg;
  logic rx_fs_int, tx_fs_int, slot_strobe, tx_active, of1_bit, rx_pin, tx_pin;
  logic rx_pin_o, rx_pin_oe, tx_pin_o, tx_pin_oe, rx_fs, tx_fs, rx_gin, tx_gin, if1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsp_pin_ctl dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .sync_mode_i(sync_mode), .buf_en_sel_i(buf_en_sel),
    .rx_dir_out_i(rx_dir_out), .tx_dir_out_i(tx_dir_out), .net_mode_i(net_mode),
    .rx_gpio_sel_i(rx_gsel), .rx_gpio_cfg_i(rx_gcfg), .rx_gpio_out_i(rx_gout),
    .tx_gpio_sel_i(tx_gsel), .tx_gpio_cfg_i(tx_gcfg), .tx_gpio_out_i(tx_gout),
    .rx_fs_int_i(rx_fs_int), .tx_fs_int_i(tx_fs_int), .slot_strobe_i(slot_strobe),
    .tx_active_i(tx_active), .of1_bit_i(of1_bit), .rx_pin_i(rx_pin), .tx_pin_i(tx_pin),
    .rx_pin_o(rx_pin_o), .rx_pin_oe_o(rx_pin_oe), .tx_pin_o(tx_pin_o), .tx_pin_oe_o(tx_pin_oe),
    .rx_fs_o(rx_fs), .tx_fs_o(tx_fs), .rx_gpio_in_o(rx_gin), .tx_gpio_in_o(tx_gin),
    .if1_o(if1)
  );

  function automatic logic [8:0] outs();
    return {rx_pin_o, rx_pin_oe, tx_pin_o, tx_pin_oe, rx_fs, tx_fs, rx_gin, tx_gin, if1};
  endfunction

  // expected outputs from the requirements
  function automatic logic [8:0] model(
    input logic rgs, input logic tgs, input logic [1:0] rcfg, input logic [1:0] tcfg,
    input logic syn, input logic tebe, input logic rdir, input logic tdir,
    input logic frx, input logic ftx, input logic prx, input logic ptx,
    input logic grx, input logic gtx, input logic tact, input logic of1, input logic if1v);
    logic rpo, roe, tpo, toe, rfs, tfs, rgi, tgi;
    {rpo, roe, tpo, toe, rfs, tfs, rgi, tgi} = '0;
    if (tgs) begin
      if (tcfg == 2'd1) tgi = ptx;
      else if (tcfg == 2'd2) begin tpo = gtx; toe = 1'b1; end
    end else if (tdir) begin
      tpo = ftx; toe = 1'b1; tfs = ftx;
    end else begin
      tfs = ptx;
    end
    if (rgs) begin
      if (rcfg == 2'd1) rgi = prx;
      else if (rcfg == 2'd2) begin rpo = grx; roe = 1'b1; end
      rfs = syn ? tfs : 1'b0;
    end else if (!syn) begin
      if (rdir) begin rpo = frx; roe = 1'b1; rfs = frx; end
      else rfs = prx;
    end else begin
      rfs = tfs;
      if (!tebe) begin
        if (rdir) begin rpo = of1; roe = 1'b1; end
      end else if (rdir) begin
        rpo = tact; roe = 1'b1;
      end
    end
    return {rpo, roe, tpo, toe, rfs, tfs, rgi, tgi, if1v};
  endfunction

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYC);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    logic exp_of1, exp_if1, stb;
    string tag;

    // R1: active inputs during reset
    sync_mode = 1'b0; buf_en_sel = 1'b0; rx_dir_out = 1'b1; tx_dir_out = 1'b1; net_mode = 1'b0;
    rx_gsel = 1'b1; rx_gcfg = 2'd2; rx_gout = 1'b1;
    tx_gsel = 1'b0; tx_gcfg = 2'd0; tx_gout = 1'b1;
    rx_fs_int = 1'b1; tx_fs_int = 1'b1; slot_strobe = 1'b0; tx_active = 1'b1;
    of1_bit = 1'b1; rx_pin = 1'b1; tx_pin = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset state", outs(), 9'b0);

    // R2: release, no edge yet -> still disconnected
    rst_ni = 1'b1;
    #1;
    chk("R2 before first edge", outs(), 9'b0);
    @(posedge clk); #1;
    // R3 rx GP out, R5 tx fs out, R12 gp inputs 0
    chk("R2 after first edge", outs(), 9'b11_11_0_1_0_0_0);

    // exhaustive role sweep; net=1 and slot=0 keep flags static
    net_mode = 1'b1; slot_strobe = 1'b0; of1_bit = 1'b1;
    for (int c = 0; c < 1024; c++) begin
      @(negedge clk);
      rx_gsel = c[0]; tx_gsel = c[1]; rx_gcfg = c[3:2]; tx_gcfg = c[5:4];
      sync_mode = c[6]; buf_en_sel = c[7]; rx_dir_out = c[8]; tx_dir_out = c[9];
      if (c[0]) tag = "R3 rx GP";
      else if (!c[6]) tag = "R4 async rx fs";
      else if (!c[7]) tag = c[8] ? "R7 flag out" : "R9 flag in";
      else tag = c[8] ? "R10 buffer enable" : "R11 idle";
      @(posedge clk); #1;
      for (int p = 0; p < 128; p++) begin
        rx_fs_int = p[0]; tx_fs_int = p[1]; rx_pin = p[2]; tx_pin = p[3];
        rx_gout = p[4]; tx_gout = p[5]; tx_active = p[6];
        #1;
        // R5 R6 R12 also compared in every vector
        chk(tag, outs(), model(c[0], c[1], c[3:2], c[5:4], c[6], c[7], c[8], c[9],
                               p[0], p[1], p[2], p[3], p[4], p[5], p[6], 1'b0, 1'b0));
      end
    end

    // flag output timing: sync, flag out, tx fs output
    @(negedge clk);
    rx_gsel = 1'b0; tx_gsel = 1'b0; sync_mode = 1'b1; buf_en_sel = 1'b0;
    rx_dir_out = 1'b1; tx_dir_out = 1'b1;
    tx_fs_int = 1'b0; slot_strobe = 1'b0; net_mode = 1'b0;
    @(posedge clk);
    exp_of1 = 1'b0; stb = 1'b0; lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      chk(stb ? "R7 of1 load" : "R8 of1 hold", {rx_pin_oe, rx_pin_o}, {7'b0, 1'b1, exp_of1});
      lf = lfsr_next(lf);
      of1_bit = lf[0]; tx_fs_int = lf[1] & lf[2]; slot_strobe = lf[3] & lf[4];
      net_mode = lf[5];
      @(posedge clk);
      stb = net_mode ? slot_strobe : tx_fs_int;
      if (stb) exp_of1 = of1_bit;
    end

    // flag input timing
    @(negedge clk);
    tx_fs_int = 1'b0; slot_strobe = 1'b0; rx_dir_out = 1'b0;
    @(posedge clk);
    exp_if1 = 1'b0; stb = 1'b0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      chk(stb ? "R9 if1 capture" : "R9 if1 hold", {rx_pin_oe, if1}, {8'b0, exp_if1});
      lf = lfsr_next(lf);
      rx_pin = lf[0]; tx_fs_int = lf[1] & lf[2]; slot_strobe = lf[3] & lf[4];
      net_mode = lf[5];
      @(posedge clk);
      stb = net_mode ? slot_strobe : tx_fs_int;
      if (stb) exp_if1 = rx_pin;
    end

    // R9: if1 held while another mode sees strobes
    @(negedge clk);
    tx_fs_int = 1'b0; slot_strobe = 1'b0; sync_mode = 1'b0;
    @(posedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      lf = lfsr_next(lf);
      rx_pin = lf[0]; tx_fs_int = lf[1]; slot_strobe = lf[2]; net_mode = lf[3];
    end
    @(negedge clk);
    chk("R9 if1 hold other mode", {8'b0, if1}, {8'b0, exp_if1});

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule